// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Software or a host controller loads them in one of two ways. One way writes them as halves over the write data bus, one half per write-clock edge. The other way shifts them in one bit per write-clock edge. Either way, both offsets can be read back half by half on a read data bus, one half per read-clock edge. Master reset chooses the loading method, and the choice stays fixed until the next master reset.

The block also decodes the shared control pins. While the load pin is high, the write-enable and read-enable pins ask the surrounding FIFO for a memory write or a memory read. While the load pin is low, the same pins reach the offset registers instead. The offset width equals log2 of the FIFO depth. Each offset is split into a low half of `ceil(w/2)` bits and a high half holding the remaining bits. The FIFO memory, the flag comparators and the bus-width matching are outside this block. The control decode works the same way whether the FIFO runs in standard mode or in first-word-fall-through mode.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst_ni` is low, both offsets take their default values (7 and 7), both half pointers return to step 0, `rd_data_o` is zero, and the level of `ser_mode_i` is captured as the loading method (1 = serial, 0 = parallel).
- R2: After `rst_ni` rises, a change on `ser_mode_i` has no effect on the loading method.
- R3: In parallel mode, each write-clock edge with `load_ni`=0 and `wen_ni`=0 stores `wr_data_i[HALF_W-1:0]` into the next half. The halves go in this order: step 0 empty low, step 1 empty high, step 2 full low, step 3 full high. A high half takes only as many low bus bits as it is wide.
- R4: Each read-clock edge with `load_ni`=0 and `ren_ni`=0 places the next half on `rd_data_o`, in the same four-step order. The half sits in the low bits and all upper bits are zero. At any other read-clock edge, `rd_data_o` holds its value.
- R5: The write pointer and the read pointer are independent. Each one advances only on its own qualifying access and wraps from step 3 back to step 0.
- R6: In serial mode, each write-clock edge with `load_ni`=0 and `sen_ni`=0 shifts in `ser_data_i`. After 2×OFF_W shifts, the first bit has reached bit 0 of the empty offset and the last bit has reached the MSB of the full offset.
- R7: In serial mode, parallel offset writes change neither offset and do not advance the write pointer.
- R8: In parallel mode, `sen_ni` activity changes neither offset.
- R9: `mem_we_o` = `load_ni` & !`wen_ni` and `mem_re_o` = `load_ni` & !`ren_ni`. While `load_ni`=1, the offsets, both pointers and `rd_data_o` do not change.
- R10: Readback works in serial mode exactly as it does in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| ser_mode_i | input | 1 | Loading method, sampled only during reset (1 = serial) |
| load_ni | input | 1 | Active-low select of offset access instead of memory access |
| wen_ni | input | 1 | Active-low write enable |
| ren_ni | input | 1 | Active-low read enable |
| sen_ni | input | 1 | Active-low serial shift enable |
| ser_data_i | input | 1 | Serial offset bit |
| wr_data_i | input | DATA_W | Write data bus |
| rd_data_o | output | DATA_W | Offset readback bus, zero-extended half |
| mem_we_o | output | 1 | Memory write request |
| mem_re_o | output | 1 | Memory read request |
| empty_off_o | output | OFF_W | Almost-empty offset |
| full_off_o | output | OFF_W | Almost-full offset |

## Verification
Parallel loading is tried with a table of offset pairs: all zeros, all ones, alternating bits, and values that fill only one half. Each pair is written and then read back, so a swapped half, a misplaced step or a truncated high half shows up as a wrong value. The upper bus bits are driven to ones during writes. This separates correct slicing and zero-extension from leakage of those upper bits. The serial test shifts in an asymmetric 20-bit pattern, which tells the correct bit direction apart from a reversed one. Directed cases then drive the pins that should be ignored: serial-enable pulses in parallel mode, parallel writes in serial mode, a mode-pin change after reset, and memory-side cycles. Each case checks that the offsets and both pointers are unaffected.

// File: rtl/fofs_pkg.sv
package fofs_pkg;
  typedef enum logic [1:0] {
    STEP_E_LO = 2'd0,
    STEP_E_HI = 2'd1,
    STEP_F_LO = 2'd2,
    STEP_F_HI = 2'd3
  } step_e;

  function automatic step_e step_next(step_e s);
    case (s)
      STEP_E_LO: return STEP_E_HI;
      STEP_E_HI: return STEP_F_LO;
      STEP_F_LO: return STEP_F_HI;
      default:   return STEP_E_LO;
    endcase
  endfunction
endpackage

// File: rtl/fofs_decode.sv
module fofs_decode (
  input  logic ser_mode_i,
  input  logic load_ni,
  input  logic wen_ni,
  input  logic ren_ni,
  input  logic sen_ni,
  output logic mem_we_o,
  output logic mem_re_o,
  output logic par_wr_o,
  output logic par_rd_o,
  output logic ser_sh_o
);
  always_comb begin
    mem_we_o = load_ni & ~wen_ni;
    mem_re_o = load_ni & ~ren_ni;
    par_wr_o = ~load_ni & ~wen_ni & ~ser_mode_i;
    ser_sh_o = ~load_ni & ~sen_ni & ser_mode_i;
    par_rd_o = ~load_ni & ~ren_ni;
  end

  always_comb begin
    p_one_path_r8: assert (!(par_wr_o && ser_sh_o));
  end
endmodule

// File: rtl/fofs_wr_side.sv
module fofs_wr_side
  import fofs_pkg::*;
#(
  parameter int OFF_W     = 10,
  parameter int HALF_W    = 5,
  parameter int EMPTY_DEF = 7,
  parameter int FULL_DEF  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_wr_i,
  input  logic              ser_sh_i,
  input  logic              ser_data_i,
  input  logic [HALF_W-1:0] wr_half_i,
  output logic [OFF_W-1:0]  empty_off_o,
  output logic [OFF_W-1:0]  full_off_o,
  output step_e             wstep_o
);
  localparam int HI_W = OFF_W - HALF_W;

  logic [OFF_W-1:0] empty_q, full_q;
  step_e            wstep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= OFF_W'(EMPTY_DEF);
      full_q  <= OFF_W'(FULL_DEF);
      wstep_q <= STEP_E_LO;
    end else if (ser_sh_i) begin
      // first bit in ends at empty LSB, last at full MSB
      {full_q, empty_q} <= {ser_data_i, full_q, empty_q[OFF_W-1:1]};
    end else if (par_wr_i) begin
      case (wstep_q)
        STEP_E_LO: empty_q[HALF_W-1:0]    <= wr_half_i;
        STEP_E_HI: empty_q[OFF_W-1:HALF_W] <= wr_half_i[HI_W-1:0];
        STEP_F_LO: full_q[HALF_W-1:0]     <= wr_half_i;
        default:   full_q[OFF_W-1:HALF_W]  <= wr_half_i[HI_W-1:0];
      endcase
      wstep_q <= step_next(wstep_q);
    end
  end

  assign empty_off_o = empty_q;
  assign full_off_o  = full_q;
  assign wstep_o     = wstep_q;

  p_wptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_wr_i |=> wstep_q == step_e'(2'($past(wstep_q) + 2'd1)));

  p_wptr_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_wr_i && wstep_q == STEP_F_HI) |=> wstep_q == STEP_E_LO);

  p_ser_ptr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_sh_i |=> $stable(wstep_q));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_wr_i && !ser_sh_i) |=> ($stable(empty_q) && $stable(full_q) && $stable(wstep_q)));
endmodule

// File: rtl/fofs_rd_side.sv
module fofs_rd_side
  import fofs_pkg::*;
#(
  parameter int OFF_W  = 10,
  parameter int HALF_W = 5,
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_rd_i,
  input  logic [OFF_W-1:0]  empty_off_i,
  input  logic [OFF_W-1:0]  full_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output step_e             rstep_o
);
  localparam int HI_W = OFF_W - HALF_W;

  step_e             rstep_q;
  logic [DATA_W-1:0] rd_q, sel;

  always_comb begin
    sel = '0;
    case (rstep_q)
      STEP_E_LO: sel[HALF_W-1:0] = empty_off_i[HALF_W-1:0];
      STEP_E_HI: sel[HI_W-1:0]   = empty_off_i[OFF_W-1:HALF_W];
      STEP_F_LO: sel[HALF_W-1:0] = full_off_i[HALF_W-1:0];
      default:   sel[HI_W-1:0]   = full_off_i[OFF_W-1:HALF_W];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      rstep_q <= STEP_E_LO;
    end else if (par_rd_i) begin
      rd_q    <= sel;
      rstep_q <= step_next(rstep_q);
    end
  end

  assign rd_data_o = rd_q;
  assign rstep_o   = rstep_q;

  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_rd_i |=> ($stable(rd_q) && $stable(rstep_q)));

  p_rd_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q[DATA_W-1:HALF_W] == '0);

  p_rptr_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_rd_i && rstep_q == STEP_F_HI) |=> rstep_q == STEP_E_LO);
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import fofs_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int DATA_W    = 36,
  parameter int EMPTY_DEF = 7,
  parameter int FULL_DEF  = 7,
  localparam int OFF_W    = $clog2(DEPTH),
  localparam int HALF_W   = (OFF_W + 1) / 2
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              ser_mode_i,
  input  logic              load_ni,
  input  logic              wen_ni,
  input  logic              ren_ni,
  input  logic              sen_ni,
  input  logic              ser_data_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [OFF_W-1:0]  empty_off_o,
  output logic [OFF_W-1:0]  full_off_o
);
  logic  ser_mode_q;
  logic  par_wr, par_rd, ser_sh;
  step_e wstep, rstep;

  // method is sampled only while master reset is held
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) ser_mode_q <= ser_mode_i;
    else         ser_mode_q <= ser_mode_q;
  end

  fofs_decode u_dec (
    .ser_mode_i (ser_mode_q),
    .load_ni    (load_ni),
    .wen_ni     (wen_ni),
    .ren_ni     (ren_ni),
    .sen_ni     (sen_ni),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .par_wr_o   (par_wr),
    .par_rd_o   (par_rd),
    .ser_sh_o   (ser_sh)
  );

  fofs_wr_side #(
    .OFF_W(OFF_W), .HALF_W(HALF_W), .EMPTY_DEF(EMPTY_DEF), .FULL_DEF(FULL_DEF)
  ) u_wr (
    .clk_i       (wclk_i),
    .rst_ni      (rst_ni),
    .par_wr_i    (par_wr),
    .ser_sh_i    (ser_sh),
    .ser_data_i  (ser_data_i),
    .wr_half_i   (wr_data_i[HALF_W-1:0]),
    .empty_off_o (empty_off_o),
    .full_off_o  (full_off_o),
    .wstep_o     (wstep)
  );

  fofs_rd_side #(
    .OFF_W(OFF_W), .HALF_W(HALF_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .par_rd_i    (par_rd),
    .empty_off_i (empty_off_o),
    .full_off_i  (full_off_o),
    .rd_data_o   (rd_data_o),
    .rstep_o     (rstep)
  );

  p_mode_fixed_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $changed(ser_mode_i) |=> $stable(ser_mode_q));

  p_mem_excl_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !load_ni |-> (!mem_we_o && !mem_re_o));

  p_par_ignored_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (ser_mode_q && sen_ni && !load_ni && !wen_ni) |=>
      ($stable(empty_off_o) && $stable(full_off_o) && $stable(wstep)));

  p_rd_wr_indep_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ren_ni || !load_ni && ren_ni) |=> $stable(rstep));
endmodule

// File: tb/flag_offset_loader_test.sv
module flag_offset_loader_test;
  localparam int DW = 36;
  localparam int OW = 10;
  localparam int HW = 5;

  logic clk = 1'b0;
  logic rst_ni, ser_mode, load_n, wen_n, ren_n, sen_n, sdat;
  logic [DW-1:0] wdat, rdat;
  logic mem_we, mem_re;
  logic [OW-1:0] e_off, f_off;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flag_offset_loader uut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .ser_mode_i(ser_mode),
    .load_ni(load_n), .wen_ni(wen_n), .ren_ni(ren_n), .sen_ni(sen_n),
    .ser_data_i(sdat), .wr_data_i(wdat), .rd_data_o(rdat),
    .mem_we_o(mem_we), .mem_re_o(mem_re),
    .empty_off_o(e_off), .full_off_o(f_off)
  );

  localparam logic [OW-1:0] VE [6] = '{10'h000, 10'h3FF, 10'h2AA, 10'h01F, 10'h3E0, 10'h135};
  localparam logic [OW-1:0] VF [6] = '{10'h3FF, 10'h000, 10'h155, 10'h3E0, 10'h01F, 10'h2CA};

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    load_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1; sen_n = 1'b1; sdat = 1'b0;
    wdat = '1;
  endtask

  task automatic cyc(input logic ld, input logic we, input logic re, input logic se,
                     input logic sd, input logic [DW-1:0] wd);
    @(negedge clk);
    load_n = ld; wen_n = we; ren_n = re; sen_n = se; sdat = sd; wdat = wd;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic pwrite(input logic [HW-1:0] h);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, {{(DW-HW){1'b1}}, h});
  endtask

  task automatic pread();
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    idle();
    ser_mode = mode;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  function automatic logic [DW-1:0] zx(input logic [HW-1:0] h);
    return {{(DW-HW){1'b0}}, h};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle();
    rst_ni = 1'b1;
    ser_mode = 1'b0;
    do_reset(1'b0);

    // R1 reset state
    chk("R1 empty default", DW'(e_off), DW'(7));
    chk("R1 full default", DW'(f_off), DW'(7));
    chk("R1 rdata zero", rdat, '0);
    pread(); chk("R1 read step0", rdat, zx(5'd7));
    pread(); chk("R1 read step1", rdat, zx(5'd0));
    pread(); chk("R1 read step2", rdat, zx(5'd7));
    pread(); chk("R1 read step3", rdat, zx(5'd0));

    // R3/R4/R5 vector table: write four halves, read four halves
    for (int v = 0; v < 6; v++) begin
      pwrite(VE[v][HW-1:0]);
      pwrite(VE[v][OW-1:HW]);
      pwrite(VF[v][HW-1:0]);
      pwrite(VF[v][OW-1:HW]);
      chk("R3 empty offset", DW'(e_off), DW'(VE[v]));
      chk("R3 full offset", DW'(f_off), DW'(VF[v]));
      pread(); chk("R4 read e_lo", rdat, zx(VE[v][HW-1:0]));
      pread(); chk("R4 read e_hi", rdat, zx(VE[v][OW-1:HW]));
      pread(); chk("R4 read f_lo", rdat, zx(VF[v][HW-1:0]));
      pread(); chk("R4 read f_hi", rdat, zx(VF[v][OW-1:HW]));
    end

    // R5 wrap: write pointer back at step 0
    pwrite(5'h1B);
    chk("R5 wrap to empty low", DW'(e_off), DW'({VE[5][OW-1:HW], 5'h1B}));
    chk("R5 full untouched", DW'(f_off), DW'(VF[5]));
    // R5 independence: read pointer still at step 0 after writes
    pread(); chk("R5 read ptr independent", rdat, zx(5'h1B));

    // R8 serial enable ignored in parallel mode
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, i[0], '1);
    chk("R8 empty stable", DW'(e_off), DW'({VE[5][OW-1:HW], 5'h1B}));
    chk("R8 full stable", DW'(f_off), DW'(VF[5]));

    // R9 memory decode and no register effect
    @(negedge clk);
    load_n = 1'b1; wen_n = 1'b0; ren_n = 1'b0; wdat = '0;
    #1;
    chk("R9 mem_we", DW'(mem_we), DW'(1));
    chk("R9 mem_re", DW'(mem_re), DW'(1));
    @(posedge clk); #1;
    chk("R9 rdata hold", rdat, zx(5'h1B));
    chk("R9 empty hold", DW'(e_off), DW'({VE[5][OW-1:HW], 5'h1B}));
    idle();
    #1;
    chk("R9 mem_we idle", DW'(mem_we), DW'(0));
    chk("R9 mem_re idle", DW'(mem_re), DW'(0));
    @(negedge clk);
    load_n = 1'b0; wen_n = 1'b0; ren_n = 1'b0;
    #1;
    chk("R9 no mem when load low", DW'({mem_we, mem_re}), DW'(0));
    idle();
    // write pointer at step 1: next write lands in empty high
    pwrite(5'h0A);
    chk("R9 wptr held", DW'(e_off), DW'({5'h0A, 5'h1B}));
    pread(); chk("R9 rptr held", rdat, zx(5'h0A));

    // serial mode
    do_reset(1'b1);
    chk("R1 serial reset empty", DW'(e_off), DW'(7));
    ser_mode = 1'b0; // R2: must not change the method
    begin
      logic [2*OW-1:0] pat;
      pat = {10'h2C9, 10'h0B6};
      for (int i = 0; i < 2*OW; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, pat[i], '1);
      chk("R6 serial empty", DW'(e_off), DW'(10'h0B6));
      chk("R6 serial full", DW'(f_off), DW'(10'h2C9));
    end
    // R7 and R2: parallel writes ignored
    pwrite(5'h11);
    pwrite(5'h02);
    chk("R7 empty unchanged", DW'(e_off), DW'(10'h0B6));
    chk("R7 full unchanged", DW'(f_off), DW'(10'h2C9));
    // R10 readback in serial mode
    pread(); chk("R10 read e_lo", rdat, zx(5'h16));
    pread(); chk("R10 read e_hi", rdat, zx(5'h05));
    pread(); chk("R10 read f_lo", rdat, zx(5'h09));
    pread(); chk("R10 read f_hi", rdat, zx(5'h16));
    pread(); chk("R5 read wrap", rdat, zx(5'h16));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule